// File: doc/BRIEF.md
# Banked GPIO Port Register File

This block holds the output values and pin directions for a set of general-purpose pins and drives the pads from them. Pins are grouped into banks of a fixed number of lines, and each bank exposes two 32-bit registers on a simple strobe bus. The data register sets what the pin drives. The direction register picks, bit by bit, whether the pin is an input or an output. Reading the data register returns a level for each line. For an input line that is the pad level after two synchronizing flops. For an output line it is the value being driven.

Banks sit at addresses spaced eight bytes apart, starting one bank step above zero. A 16-byte window at 0x90 is reserved for a separate interrupt block, so every bank that would land in or above that window moves up by 0x10. Any address that does not belong to a bank reads as zero and ignores writes. That includes the window itself.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every implemented direction bit is 1, so all pins are inputs and `pin_oe` is all zero. Every data bit is 0, so `pin_out` is all zero.
- R2: Bank b has its base at (b+1)*8. When that value is 0x90 or more, 0x10 is added to it. The data register sits at base+0x0 and the direction register at base+0x4. Address bits [1:0] do not take part in decode.
- R3: Addresses 0x90 to 0x9F select no bank. A read there returns 0, and a write there changes no pin and no register.
- R4: A direction bit of 1 makes its pin an input (`pin_oe`=0). A direction bit of 0 makes it an output (`pin_oe`=1). `pin_oe` follows a direction write in the cycle after the write edge.
- R5: A write to a data register sets `pin_out` for that bank's lines in the cycle after the write edge.
- R6: A data read returns, for each line whose direction bit is 1, the `pin_in` level after two synchronizer flops. A level applied before one clock edge first shows up in a read issued at the third edge after it. For each line whose direction bit is 0, the read returns the data bit.
- R7: Only bits [LINES-1:0] of a bank register are implemented. Bits [31:LINES] read 0, and writes to them are discarded.
- R8: In the last bank, lines at or above the pin count are not implemented. Those bits read 0 in both registers.
- R9: Any other address that hits no bank register, whether below the first bank or above the last, reads 0 and ignores writes.
- R10: `bus_rdata` is registered. It loads on the edge where `bus_rd` is high and holds its value until the next read. When a read and a write hit the same register in the same cycle, the read returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address (word granular) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Pad input levels |
| pin_out | output | NUM_PINS | Pad output values |
| pin_oe | output | NUM_PINS | Pad output enables, 1 = drive |

## Verification
A read and a write can fall in the same cycle. When both target the same register, the read must see the contents from before the write, and the write must still land. The bench provokes this by raising both strobes on one bank's data register and comparing the returned word with the old value, then with the new one on a following read. A second overlap comes from an input level changing while reads are in progress. The bench changes `pin_in` and reads back-to-back, and it expects the old level on the first two reads and the new level only on the third.

// File: rtl/gbr_pkg.sv
package gbr_pkg;

  localparam int unsigned HOLE_LO   = 32'h90;
  localparam int unsigned HOLE_HI   = 32'h9F;
  localparam int unsigned HOLE_SKIP = 32'h10;
  localparam int unsigned BANK_STEP = 8;
  localparam int unsigned DIR_OFS   = 4;

  // Byte address of the data register of bank b.
  function automatic int unsigned bank_base(input int unsigned b);
    int unsigned a;
    a = (b + 1) * BANK_STEP;
    if (a >= HOLE_LO) a = a + HOLE_SKIP;
    return a;
  endfunction

  // Number of implemented lines in bank b.
  function automatic int unsigned lines_used(input int unsigned b,
                                             input int unsigned lines,
                                             input int unsigned pins);
    int unsigned rest;
    rest = pins - b * lines;
    return (rest > lines) ? lines : rest;
  endfunction

endpackage

// File: rtl/gbr_sync.sv
module gbr_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gbr_addr_dec.sv
module gbr_addr_dec
  import gbr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NB     = 20
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NB-1:0]     data_sel,
  output logic [NB-1:0]     dir_sel
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(bank_base(b));
    localparam logic [ADDR_W-1:0] DIR_A  = ADDR_W'(bank_base(b) + DIR_OFS);
    assign data_sel[b] = (addr[ADDR_W-1:2] == DATA_A[ADDR_W-1:2]);
    assign dir_sel[b]  = (addr[ADDR_W-1:2] == DIR_A[ADDR_W-1:2]);
  end
endmodule

// File: rtl/gbr_bank.sv
module gbr_bank #(
  parameter int LINES = 8,
  parameter int USED  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_data,
  input  logic             wr_dir,
  input  logic [LINES-1:0] wdata,
  input  logic [LINES-1:0] pin_sync,
  output logic [LINES-1:0] data_q,
  output logic [LINES-1:0] dir_q,
  output logic [LINES-1:0] rd_val,
  output logic [LINES-1:0] oe
);
  localparam logic [LINES-1:0] MASK = LINES'((64'd1 << USED) - 64'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= MASK;
    end else begin
      if (wr_data) data_q <= wdata & MASK;
      if (wr_dir)  dir_q  <= wdata & MASK;
    end
  end

  assign rd_val = ((dir_q & pin_sync) | (~dir_q & data_q)) & MASK;
  assign oe     = ~dir_q & MASK;

  // R1: leaving reset, every implemented line is an input with data 0
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (dir_q == MASK && data_q == '0));

  // R5: a data write lands on the next edge
  assert_data_write_R5: assert property (@(posedge clk) disable iff (rst)
    wr_data |=> data_q == ($past(wdata) & MASK));

  // R4: direction changes only through a direction write
  assert_dir_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !wr_dir |=> $stable(dir_q));
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gbr_pkg::*;
#(
  parameter int NUM_PINS = 156,
  parameter int LINES    = 8,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);
  localparam int NB    = (NUM_PINS + LINES - 1) / LINES;
  localparam int PAD_W = NB * LINES;

  logic [NUM_PINS-1:0] sync_q;
  logic [PAD_W-1:0]    sync_pad;
  logic [NB-1:0]       data_sel, dir_sel;
  logic [LINES-1:0]    bank_data [NB];
  logic [LINES-1:0]    bank_dir  [NB];
  logic [LINES-1:0]    bank_rd   [NB];
  logic [LINES-1:0]    bank_oe   [NB];
  logic [LINES-1:0]    rd_mux;
  logic                any_sel;
  logic                in_hole;

  gbr_sync #(.W(NUM_PINS)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (sync_q)
  );

  assign sync_pad[NUM_PINS-1:0] = sync_q;
  if (PAD_W > NUM_PINS) begin : g_pad
    assign sync_pad[PAD_W-1:NUM_PINS] = '0;
  end

  gbr_addr_dec #(.ADDR_W(ADDR_W), .NB(NB)) u_dec (
    .addr     (bus_addr),
    .data_sel (data_sel),
    .dir_sel  (dir_sel)
  );

  assign any_sel = (|data_sel) | (|dir_sel);
  assign in_hole = (32'(bus_addr) >= HOLE_LO) && (32'(bus_addr) <= HOLE_HI);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam int USED = lines_used(b, LINES, NUM_PINS);
    gbr_bank #(.LINES(LINES), .USED(USED)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .wr_data  (bus_wr & data_sel[b]),
      .wr_dir   (bus_wr & dir_sel[b]),
      .wdata    (bus_wdata[LINES-1:0]),
      .pin_sync (sync_pad[b*LINES +: LINES]),
      .data_q   (bank_data[b]),
      .dir_q    (bank_dir[b]),
      .rd_val   (bank_rd[b]),
      .oe       (bank_oe[b])
    );
    assign pin_out[b*LINES +: USED] = bank_data[b][USED-1:0];
    assign pin_oe[b*LINES +: USED]  = bank_oe[b][USED-1:0];
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NB; b++) begin
      if (data_sel[b]) rd_mux = rd_mux | bank_rd[b];
      if (dir_sel[b])  rd_mux = rd_mux | bank_dir[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= {{(32-LINES){1'b0}}, rd_mux};
  end

  // R2: at most one register is selected by any address
  assert_single_select_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({data_sel, dir_sel}));

  // R3: the interrupt window decodes to nothing and reads zero
  assert_hole_empty_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && in_hole) |=> bus_rdata == 32'd0);

  // R7: unimplemented upper bits always read zero
  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rdata[31:LINES] == '0);

  // R9: unmapped reads return zero
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !any_sel) |=> bus_rdata == 32'd0);

  // R10: read data holds between reads
  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/sim_gpio_bank_regs.sv
`timescale 1ns/1ps
module sim_gpio_bank_regs;
  localparam int NUM_PINS = 156;
  localparam int LINES    = 8;
  localparam int ADDR_W   = 12;
  localparam int NB       = (NUM_PINS + LINES - 1) / LINES;

  logic                clk = 0;
  logic                rst = 1;
  logic                bus_wr = 0, bus_rd = 0;
  logic [ADDR_W-1:0]   bus_addr = '0;
  logic [31:0]         bus_wdata = '0;
  logic [31:0]         bus_rdata;
  logic [NUM_PINS-1:0] pin_in = '0;
  logic [NUM_PINS-1:0] pin_out, pin_oe;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] m_data [NB];
  logic [7:0] m_dir  [NB];

  always #5 clk = ~clk;

  gpio_bank_regs #(.NUM_PINS(NUM_PINS), .LINES(LINES), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic int base_of(input int b);
    int a;
    a = (b + 1) * 8;
    if (a >= 'h90) a = a + 'h10;
    return a;
  endfunction

  function automatic logic [7:0] mask_of(input int b);
    int n;
    n = NUM_PINS - b * 8;
    if (n >= 8) return 8'hFF;
    return 8'((1 << n) - 1);
  endfunction

  function automatic logic [NUM_PINS-1:0] exp_out();
    logic [NUM_PINS-1:0] v;
    for (int p = 0; p < NUM_PINS; p++) v[p] = m_data[p/8][p%8];
    return v;
  endfunction

  function automatic logic [NUM_PINS-1:0] exp_oe();
    logic [NUM_PINS-1:0] v;
    for (int p = 0; p < NUM_PINS; p++) v[p] = ~m_dir[p/8][p%8];
    return v;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // All bus tasks start and end at a falling edge.
  task automatic bus_write(input int addr, input logic [31:0] d);
    bus_wr = 1; bus_addr = ADDR_W'(addr); bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic bus_read(input int addr, output logic [31:0] d);
    bus_rd = 1; bus_addr = ADDR_W'(addr);
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic bus_rw(input int addr, input logic [31:0] wd,
                        output logic [31:0] rd);
    bus_rd = 1; bus_wr = 1; bus_addr = ADDR_W'(addr); bus_wdata = wd;
    @(negedge clk);
    bus_rd = 0; bus_wr = 0;
    rd = bus_rdata;
  endtask

  task automatic check_pins(input string req);
    check(req, "pin_out", 256'(pin_out), 256'(exp_out()));
    check(req, "pin_oe",  256'(pin_oe),  256'(exp_oe()));
  endtask

  task automatic t_reset();
    logic [31:0] r;
    check("R1", "pin_oe after reset", 256'(pin_oe), 256'(0));
    check("R1", "pin_out after reset", 256'(pin_out), 256'(0));
    bus_read(base_of(0) + 4, r);
    check("R1", "bank0 dir", 256'(r), 256'(32'hFF));
    bus_read(base_of(0), r);
    check("R1", "bank0 data", 256'(r), 256'(0));
    bus_read(base_of(NB-1) + 4, r);
    check("R8", "last bank dir", 256'(r), 256'(32'h0F));
  endtask

  task automatic t_all_banks();
    logic [31:0] r;
    for (int b = 0; b < NB; b++) begin
      logic [7:0] v;
      v = 8'((b * 37 + 11) ^ 8'h5A);
      bus_write(base_of(b), {24'h0, v});
      bus_write(base_of(b) + 4, 32'h0);
      m_data[b] = v & mask_of(b);
      m_dir[b]  = 8'h00;
    end
    check_pins("R2 R4 R5");
    for (int b = 0; b < NB; b++) begin
      bus_read(base_of(b), r);
      check("R2 R6 R8", $sformatf("bank%0d data", b), 256'(r), 256'(m_data[b]));
    end
    // bits [1:0] ignored: write through an offset address
    bus_write(base_of(2) + 3, 32'h3C);
    m_data[2] = 8'h3C;
    bus_read(base_of(2) + 1, r);
    check("R2", "low addr bits ignored", 256'(r), 256'(32'h3C));
    check_pins("R5");
  endtask

  task automatic t_hole();
    logic [31:0] r;
    for (int a = 'h90; a <= 'h9C; a += 4) bus_write(a, 32'hFFFF_FFFF);
    check_pins("R3 hole write");
    for (int a = 'h90; a <= 'h9C; a += 4) begin
      bus_read(a, r);
      check("R3", "hole read", 256'(r), 256'(0));
    end
    bus_read(base_of(16), r);
    check("R3", "bank16 data", 256'(r), 256'(m_data[16]));
    bus_read(base_of(17), r);
    check("R3", "bank17 data", 256'(r), 256'(m_data[17]));
    bus_read(base_of(17) + 4, r);
    check("R3", "bank17 dir", 256'(r), 256'(0));
  endtask

  task automatic t_unmapped();
    logic [31:0] r;
    int addrs [4] = '{'h000, 'h004, 'hB8, 'h200};
    foreach (addrs[i]) bus_write(addrs[i], 32'hA5A5_A5A5);
    check_pins("R9 unmapped write");
    foreach (addrs[i]) begin
      bus_read(addrs[i], r);
      check("R9", $sformatf("read %h", addrs[i]), 256'(r), 256'(0));
    end
  endtask

  task automatic t_upper();
    logic [31:0] r;
    bus_write(base_of(3), 32'hABCD_EF12);
    m_data[3] = 8'h12;
    bus_read(base_of(3), r);
    check("R7", "upper bits dropped", 256'(r), 256'(32'h12));
    bus_write(base_of(NB-1), 32'hFF);
    m_data[NB-1] = 8'h0F;
    bus_read(base_of(NB-1), r);
    check("R8", "last bank data", 256'(r), 256'(32'h0F));
    check_pins("R7 R8");
  endtask

  task automatic t_inputs();
    logic [31:0] r;
    bus_write(base_of(2), 32'h05);
    bus_write(base_of(2) + 4, 32'hF0);
    m_data[2] = 8'h05; m_dir[2] = 8'hF0;
    check_pins("R4");
    pin_in[23:16] = 8'hA0;
    bus_read(base_of(2), r);
    check("R6", "sync read 1", 256'(r), 256'(32'h05));
    bus_read(base_of(2), r);
    check("R6", "sync read 2", 256'(r), 256'(32'h05));
    bus_read(base_of(2), r);
    check("R6", "sync read 3", 256'(r), 256'(32'hA5));
    pin_in[23:16] = 8'h5F;
    repeat (3) @(negedge clk);
    bus_read(base_of(2), r);
    check("R6", "mixed in/out", 256'(r), 256'(32'h55));
  endtask

  task automatic t_collide();
    logic [31:0] r;
    bus_write(base_of(1), 32'h11);
    m_data[1] = 8'h11;
    bus_rw(base_of(1), 32'h22, r);
    m_data[1] = 8'h22;
    check("R10", "read during write", 256'(r), 256'(32'h11));
    check_pins("R10 write landed");
    repeat (4) @(negedge clk);
    check("R10", "rdata held", 256'(bus_rdata), 256'(32'h11));
    bus_read(base_of(1), r);
    check("R10", "read after write", 256'(r), 256'(32'h22));
  endtask

  initial begin
    for (int b = 0; b < NB; b++) begin
      m_data[b] = 8'h00;
      m_dir[b]  = mask_of(b);
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_all_banks();
    t_hole();
    t_unmapped();
    t_upper();
    t_inputs();
    t_collide();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule